// File: doc/BRIEF.md
# Read-Activated Hardware Option Latch

The block holds the peripheral configuration bytes of a controller. The codes for these bytes are stored in a small window of program storage, but they take no effect until software reads each location at least once after reset. The block snoops the CPU read bus. When a valid read hits a programmable location in the window, it captures the returned data byte into that location's option register and marks the location as activated.

Part of the window is tied to mask-defined constants. Reads there return fixed values and never change them. Until software activates them, the registers hold safe defaults:

- Port slew control starts with the four lowest pins of the first port in fast mode and the rest in slow mode.
- Watchdog and clock-monitor hardware enables start off, so software switches those functions on.

A status output reports when every programmable location has been read since the last reset.

Top module: `hwopt_latch`

## Requirements
- R1: While `rst_n` is low, and right after it rises, these values hold:
  - every programmable byte is 0x00, except byte 32 (slew), which is 0x0F;
  - `u1_fast` is 0x0F;
  - `wdt_hw_en`, `cmon_hw_en` and `all_act` are 0.
- R2: A cycle with `bus_rd` and `bus_vld` both high, whose `bus_addr` maps to a programmable location, stores `bus_data` into byte (bus_addr − 0x00FFA0) of `opt_bytes`. The byte is visible after that rising clock edge.
- R3: A cycle where `bus_rd` or `bus_vld` is low leaves `opt_bytes` unchanged, whatever the address and data.
- R4: Reads outside 0x00FFA0..0x00FFC3 leave `opt_bytes` unchanged. This includes addresses whose upper byte differs from 0x00.
- R5: Bytes 24..31 (addresses 0x00FFB8..0x00FFBF) always equal 0x5A XOR index, and reads of them change nothing.
- R6: A later read of an already activated location overwrites it, so the most recent read wins.
- R7: `u1_fast` equals option byte 32 (address 0x00FFC0). Bit n set means pin n of port 1 is fast.
- R8: `wdt_hw_en` is bit 0 and `cmon_hw_en` is bit 1 of option byte 33 (address 0x00FFC1).
- R9: `all_act` goes high after every one of the 28 programmable locations has been captured since reset. It stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Snooped read address |
| bus_data | input | 8 | Snooped read data |
| bus_rd | input | 1 | Read strobe |
| bus_vld | input | 1 | Data valid on this cycle |
| opt_bytes | output | 288 | Option bytes, byte i at bits [8i+7:8i] |
| u1_fast | output | 8 | Port 1 fast-slew enables |
| wdt_hw_en | output | 1 | Watchdog hardware enable |
| cmon_hw_en | output | 1 | Clock monitor hardware enable |
| all_act | output | 1 | All programmable locations activated |

## Verification
The properties assume that address, data and both strobes are settled at each rising edge. They also assume that a snooped read counts once per cycle in which both strobes are high. The stimulus drives all inputs on the falling edge, so these assumptions hold. The stimulus mixes in-window addresses, fixed locations, near misses on both sides of the window and wrong upper bytes, with each strobe dropped at random.

// File: rtl/hwopt_latch.sv
module hwopt_latch #(
  parameter int ADDR_W = 24,
  parameter logic [23:0] BASE = 24'h00FFA0,
  parameter int NLOC = 36,
  parameter int FIX_FIRST = 24,
  parameter int FIX_LAST = 31,
  parameter int SLEW_IDX = 32,
  parameter int SUPV_IDX = 33,
  parameter logic [7:0] SLEW_DEF = 8'h0F,
  parameter logic [7:0] FIX_SEED = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic              bus_rd,
  input  logic              bus_vld,
  output logic [NLOC*8-1:0] opt_bytes,
  output logic [7:0]        u1_fast,
  output logic              wdt_hw_en,
  output logic              cmon_hw_en,
  output logic              all_act
);
  localparam int IDX_W = $clog2(NLOC);

  logic [ADDR_W-1:0] off;
  logic              in_win, take;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        opt_q [NLOC];
  logic [NLOC-1:0]   act;

  assign off    = bus_addr - ADDR_W'(BASE);
  assign in_win = off < ADDR_W'(NLOC);
  assign idx    = off[IDX_W-1:0];
  assign take   = bus_rd & bus_vld & in_win;

  for (genvar g = 0; g < NLOC; g++) begin : g_loc
    if (g >= FIX_FIRST && g <= FIX_LAST) begin : g_fix
      assign opt_q[g] = FIX_SEED ^ 8'(g);
      assign act[g]   = 1'b1;
    end else begin : g_prog
      localparam logic [7:0] DEF = (g == SLEW_IDX) ? SLEW_DEF : 8'h00;
      logic [7:0] val;
      logic       seen;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val  <= DEF;
          seen <= 1'b0;
        end else if (take && idx == IDX_W'(g)) begin
          val  <= bus_data;
          seen <= 1'b1;
        end
      end
      assign opt_q[g] = val;
      assign act[g]   = seen;
    end
    assign opt_bytes[g*8 +: 8] = opt_q[g];
  end

  assign u1_fast    = opt_q[SLEW_IDX];
  assign wdt_hw_en  = opt_q[SUPV_IDX][0];
  assign cmon_hw_en = opt_q[SUPV_IDX][1];
  assign all_act    = &act;
endmodule

module hwopt_latch_chk #(
  parameter int ADDR_W = 24,
  parameter logic [23:0] BASE = 24'h00FFA0,
  parameter int NLOC = 36,
  parameter int FIX_FIRST = 24,
  parameter int FIX_LAST = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_data,
  input logic              bus_rd,
  input logic              bus_vld,
  input logic [NLOC*8-1:0] opt_bytes,
  input logic              all_act
);
  logic [ADDR_W-1:0] c_off;
  logic strobe, inw, fixw, prog;
  logic p_hit;
  logic [7:0] p_data;
  logic [ADDR_W-1:0] p_off;
  logic [7:0] seen;

  assign c_off  = bus_addr - ADDR_W'(BASE);
  assign strobe = bus_rd && bus_vld;
  assign inw    = c_off < ADDR_W'(NLOC);
  assign fixw   = c_off >= ADDR_W'(FIX_FIRST) && c_off <= ADDR_W'(FIX_LAST);
  assign prog   = inw && !fixw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_hit  <= 1'b0;
      p_data <= 8'h00;
      p_off  <= '0;
    end else begin
      p_hit  <= strobe && prog;
      p_data <= bus_data;
      p_off  <= c_off;
    end
  end

  assign seen = opt_bytes[32'(p_off)*8 +: 8];

  // R2
  capture_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_hit |-> seen == p_data);

  // R3
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(opt_bytes));

  // R4
  out_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !inw) |=> $stable(opt_bytes));

  // R5
  fixed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && fixw) |=> $stable(opt_bytes));

  // R9
  all_act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_act |=> all_act);
endmodule

bind hwopt_latch hwopt_latch_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .NLOC(NLOC),
  .FIX_FIRST(FIX_FIRST), .FIX_LAST(FIX_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
  .bus_rd(bus_rd), .bus_vld(bus_vld), .opt_bytes(opt_bytes), .all_act(all_act)
);

// File: tb/tb_hwopt_latch.sv
module tb_hwopt_latch;
  localparam int NLOC = 36;
  localparam logic [23:0] BASE = 24'h00FFA0;

  logic clk = 0, rst_n = 0;
  logic [23:0] bus_addr = '0;
  logic [7:0] bus_data = '0;
  logic bus_rd = 0, bus_vld = 0;
  logic [NLOC*8-1:0] opt_bytes;
  logic [7:0] u1_fast;
  logic wdt_hw_en, cmon_hw_en, all_act;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_b [NLOC];
  bit exp_a [NLOC];

  always #2 clk = ~clk;

  hwopt_latch dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .bus_vld(bus_vld), .opt_bytes(opt_bytes), .u1_fast(u1_fast),
    .wdt_hw_en(wdt_hw_en), .cmon_hw_en(cmon_hw_en), .all_act(all_act));

  function automatic bit is_fix(int i); return i >= 24 && i <= 31; endfunction
  function automatic logic [7:0] def_val(int i);
    if (is_fix(i)) return 8'h5A ^ 8'(i);
    return (i == 32) ? 8'h0F : 8'h00;
  endfunction
  function automatic bit exp_all();
    for (int i = 0; i < NLOC; i++) if (!is_fix(i) && !exp_a[i]) return 0;
    return 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NLOC; i++) begin exp_b[i] = def_val(i); exp_a[i] = 0; end
  endtask

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    for (int i = 0; i < NLOC; i++)
      chk(is_fix(i) ? "R5" : req, $sformatf("byte%0d", i), opt_bytes[i*8 +: 8], exp_b[i]);
    chk("R7", "u1_fast", u1_fast, exp_b[32]);
    chk("R8", "wdt_hw_en", {7'd0, wdt_hw_en}, {7'd0, exp_b[33][0]});
    chk("R8", "cmon_hw_en", {7'd0, cmon_hw_en}, {7'd0, exp_b[33][1]});
    chk("R9", "all_act", {7'd0, all_act}, {7'd0, exp_all()});
  endtask

  task automatic cyc(logic [23:0] a, logic [7:0] d, logic r, logic v);
    logic [23:0] off;
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_rd = r; bus_vld = v;
    @(posedge clk); #1;
    off = a - BASE;
    if (r && v && off < NLOC && !is_fix(int'(off))) begin
      exp_b[off] = d; exp_a[off] = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bus_rd = 0; bus_vld = 0;
    model_reset();
    #1 check_state("R1");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 check_state("R1");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R2 / R7 / R8 directed
    cyc(BASE + 24'd32, 8'hF0, 1, 1); check_state("R2");
    cyc(BASE + 24'd33, 8'h03, 1, 1); check_state("R8");
    // R6 most recent wins
    cyc(BASE + 24'd5, 8'h11, 1, 1);
    cyc(BASE + 24'd5, 8'h22, 1, 1); check_state("R6");
    // R3 missing strobes
    cyc(BASE + 24'd6, 8'hEE, 0, 1); check_state("R3");
    cyc(BASE + 24'd6, 8'hEE, 1, 0); check_state("R3");
    // R4 near misses and wrong upper byte
    cyc(24'h00FF9F, 8'h77, 1, 1); check_state("R4");
    cyc(24'h00FFC4, 8'h77, 1, 1); check_state("R4");
    cyc(24'h01FFA0, 8'h77, 1, 1); check_state("R4");
    // R5 fixed locations
    cyc(BASE + 24'd24, 8'h00, 1, 1); check_state("R5");
    cyc(BASE + 24'd31, 8'hFF, 1, 1); check_state("R5");
    // R9: all programmable but the last one, then the last
    for (int i = 0; i < NLOC - 1; i++)
      if (!is_fix(i)) cyc(BASE + 24'(i), 8'(i * 3), 1, 1);
    check_state("R9");
    cyc(BASE + 24'd35, 8'h99, 1, 1); check_state("R9");
    do_reset();
    // random
    for (int n = 0; n < 2000; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [23:0] a;
      if (sel < 7) a = BASE + 24'($urandom_range(0, NLOC - 1));
      else if (sel == 7) a = BASE - 24'($urandom_range(1, 4));
      else if (sel == 8) a = BASE + 24'($urandom_range(NLOC, NLOC + 4));
      else a = 24'($urandom);
      cyc(a, 8'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0));
      check_state("R2");
      if (n == 1000) do_reset();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule